// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Generator

This block is a two-wire serial slave that keeps a small bank of eight-bit control registers for a system clock generator. A controller writes them with one block-write sequence. After the write address, the controller must send a command byte and then a byte-count byte. Both are acknowledged, and their contents are thrown away. Every byte after that goes into the next register, starting at register 0. The transfer can end at any byte boundary with a STOP. A read address makes the slave stream the registers back from register 0. No count byte comes first.

The register outputs are decoded into the fields the clock generator uses. Register 0 holds the spread-spectrum amount, type and enable, the selected frequency code, whether that code or the strap pins set the frequency, and a global output tristate. Registers 1 to 5 are per-clock enable masks. Register 6 is a spare. While the power-down input is high, the slave lets go of the data line, ignores the bus and keeps every register value.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low during the ninth SCL pulse. Any other address byte is not acknowledged, and the rest of that transfer is ignored.
- R2: In a write, the two bytes that follow the address are acknowledged and change no register.
- R3: In a write, the data bytes after the two header bytes go to register 0, 1, 2 and upward in order, and each byte is acknowledged. A STOP after any complete byte ends the transfer and keeps every byte already stored.
- R4: In a read, the first byte the slave returns is register 0, and then the following registers come in order for as long as the controller acknowledges. A not-acknowledge ends the stream.
- R5: After reset, register 0 holds 0x00 and registers 1 to 6 hold 0xFF.
- R6: Register 0 bit 7 drives spread_narrow, bits 6:4 drive freq_code, and bit 3 drives freq_from_reg.
- R7: Register 0 bit 2 drives spread_down, bit 1 drives spread_en, and bit 0 drives all_hiz.
- R8: While pwr_dn is high, sda_oe stays low, bus activity is ignored and all registers keep their values. Writes work again once pwr_dn falls.
- R9: A byte that is cut short by a STOP or a repeated START before its eighth bit changes no register.
- R10: Write data bytes beyond register 6 are acknowledged and dropped. Read bytes beyond register 6 return 0xFF.
- R11: Registers 1 to 5 appear unchanged on cpu_en, pci_en, sdram_en_lo, sdram_en_hi and periph_en. Register 6 can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset, loads the register defaults |
| pwr_dn | input | 1 | Power-down: releases SDA and freezes the registers |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the open-drain driver pulls SDA low |
| spread_narrow | output | 1 | Spread amount: 0 wide, 1 narrow |
| freq_code | output | 3 | Frequency selection code |
| freq_from_reg | output | 1 | 1 means freq_code sets the frequency, 0 means the strap pins do |
| spread_down | output | 1 | Spread type: 0 centre, 1 down |
| spread_en | output | 1 | Spread-spectrum enable |
| all_hiz | output | 1 | Tristates all clock outputs |
| cpu_en | output | 8 | Enable mask from register 1 |
| pci_en | output | 8 | Enable mask from register 2 |
| sdram_en_lo | output | 8 | Enable mask from register 3 |
| sdram_en_hi | output | 8 | Enable mask from register 4 |
| periph_en | output | 8 | Enable mask from register 5 |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except for START and STOP. SCL high and low phases last many system clocks, so the two-flop synchronizers see every level. The bench drives SCL directly with each quarter bit lasting eight system clocks. It changes SDA only in the middle of the low phase, and it ties SDA to a wired-AND of its own pull-down and sda_oe, so both sides can drive the same line as on a real bus.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
   typedef enum logic [2:0] {
      LS_IDLE,
      LS_RX,
      LS_ACK,
      LS_TX,
      LS_MACK
   } link_st_t;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
   import cfgs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR  = 7'h69,
   parameter int         HDR_BYTES = 2,
   parameter int         NUM_REGS  = 7,
   parameter int         IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             scl_s,
   input  logic             sda_s,
   output logic             sda_drive,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [IDX_W-1:0] rd_idx,
   input  logic [7:0]       rd_data
);
   localparam int CNT_W = $clog2(HDR_BYTES + NUM_REGS + 2);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HDR_BYTES + NUM_REGS + 1);
   localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_BYTES);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HDR_BYTES + NUM_REGS);
   localparam logic [CNT_W-1:0] CNT_NUM = CNT_W'(NUM_REGS);

   link_st_t         st;
   logic             scl_p, sda_p;
   logic [2:0]       bit_cnt;
   logic             full;
   logic [7:0]       shreg;
   logic             is_rd, is_addr, mnack;
   logic [CNT_W-1:0] cnt;

   logic start_c, stop_c, rise_c, fall_c;
   logic [7:0] tx_byte;

   assign start_c = scl_s & scl_p &  sda_p & ~sda_s;
   assign stop_c  = scl_s & scl_p & ~sda_p &  sda_s;
   assign rise_c  =  scl_s & ~scl_p;
   assign fall_c  = ~scl_s &  scl_p;

   assign rd_idx  = IDX_W'(cnt);
   assign tx_byte = (cnt < CNT_NUM) ? rd_data : 8'hFF;

   assign wr_en   = !hold && (st == LS_RX) && fall_c && full && !is_addr
                    && (cnt >= CNT_HDR) && (cnt < CNT_END);
   assign wr_idx  = IDX_W'(cnt - CNT_HDR);
   assign wr_data = shreg;

   assign sda_drive = (st == LS_ACK) || ((st == LS_TX) && !shreg[7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= LS_IDLE;
         scl_p   <= 1'b1;
         sda_p   <= 1'b1;
         bit_cnt <= '0;
         full    <= 1'b0;
         shreg   <= '0;
         is_rd   <= 1'b0;
         is_addr <= 1'b0;
         mnack   <= 1'b0;
         cnt     <= '0;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
         if (hold) begin
            st <= LS_IDLE;
         end else if (start_c) begin
            st      <= LS_RX;
            is_addr <= 1'b1;
            bit_cnt <= '0;
            full    <= 1'b0;
            cnt     <= '0;
         end else if (stop_c) begin
            st <= LS_IDLE;
         end else begin
            unique case (st)
               LS_RX: begin
                  if (rise_c && !full) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) full <= 1'b1;
                  end else if (fall_c && full) begin
                     full    <= 1'b0;
                     bit_cnt <= '0;
                     if (is_addr) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           st      <= LS_ACK;
                           is_rd   <= shreg[0];
                           is_addr <= 1'b0;
                        end else begin
                           st <= LS_IDLE;
                        end
                     end else begin
                        st <= LS_ACK;
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                     end
                  end
               end
               LS_ACK: begin
                  if (fall_c) begin
                     if (is_rd) begin
                        st    <= LS_TX;
                        shreg <= tx_byte;
                     end else begin
                        st <= LS_RX;
                     end
                  end
               end
               LS_TX: begin
                  if (fall_c) begin
                     shreg   <= {shreg[6:0], 1'b1};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) begin
                        st      <= LS_MACK;
                        bit_cnt <= '0;
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                     end
                  end
               end
               LS_MACK: begin
                  if (rise_c) begin
                     mnack <= sda_s;
                  end else if (fall_c) begin
                     if (mnack) begin
                        st <= LS_IDLE;
                     end else begin
                        st    <= LS_TX;
                        shreg <= tx_byte;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // The slave may only start pulling SDA while SCL is low, so it never forms a START or STOP
   assert_drive_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive) |-> !scl_s);
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank #(
   parameter int NUM_REGS = 7,
   parameter int OUT_REGS = 6,
   parameter int IDX_W    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hold,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [OUT_REGS*8-1:0] ctrl_q
);
   generate
      if (OUT_REGS > NUM_REGS) begin : g_bad_out
         $error("cfgs_regbank: OUT_REGS exceeds NUM_REGS");
      end
   endgenerate

   logic [7:0] regs_q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [7:0] RST_VAL = (i == 0) ? 8'h00 : 8'hFF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) regs_q[i] <= RST_VAL;
         else if (wr_en && (wr_idx == IDX_W'(i))) regs_q[i] <= wr_data;
      end
   end

   for (genvar j = 0; j < OUT_REGS; j++) begin : g_out
      assign ctrl_q[j*8 +: 8] = regs_q[j];
   end

   always_comb begin
      rd_data = 8'hFF;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_idx == IDX_W'(k)) rd_data = regs_q[k];
      end
   end

   // checker state: last written index
   logic [IDX_W-1:0] last_idx;
   logic             seen_wr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_idx <= '0;
         seen_wr  <= 1'b0;
      end else if (wr_en) begin
         last_idx <= wr_idx;
         seen_wr  <= 1'b1;
      end
   end

   assert_no_write_in_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !wr_en);
   assert_wr_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_REGS));
   assert_sequential_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && seen_wr) |-> ((wr_idx == '0) || (wr_idx == IDX_W'(last_idx + 1'b1))));
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         HDR_BYTES   = 2,
   parameter int         NUM_REGS    = 7,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_dn,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       spread_narrow,
   output logic [2:0] freq_code,
   output logic       freq_from_reg,
   output logic       spread_down,
   output logic       spread_en,
   output logic       all_hiz,
   output logic [7:0] cpu_en,
   output logic [7:0] pci_en,
   output logic [7:0] sdram_en_lo,
   output logic [7:0] sdram_en_hi,
   output logic [7:0] periph_en
);
   localparam int IDX_W    = $clog2(NUM_REGS);
   localparam int OUT_REGS = 6;

   generate
      if (NUM_REGS < OUT_REGS || NUM_REGS > 64) begin : g_bad_regs
         $error("clkgen_cfg_slave: NUM_REGS must be 6..64");
      end
      if (HDR_BYTES < 0 || HDR_BYTES > 8) begin : g_bad_hdr
         $error("clkgen_cfg_slave: HDR_BYTES must be 0..8");
      end
   endgenerate

   logic scl_s, sda_s, drive;
   logic wr_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [7:0] wr_data, rd_data;
   logic [OUT_REGS*8-1:0] ctrl_q;

   cfgs_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   cfgs_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   cfgs_link #(
      .DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES),
      .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
   ) u_link (
      .clk(clk), .rst_n(rst_n), .hold(pwr_dn),
      .scl_s(scl_s), .sda_s(sda_s), .sda_drive(drive),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   cfgs_regbank #(
      .NUM_REGS(NUM_REGS), .OUT_REGS(OUT_REGS), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .hold(pwr_dn),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .ctrl_q(ctrl_q)
   );

   assign sda_oe        = drive & ~pwr_dn;
   assign spread_narrow = ctrl_q[7];
   assign freq_code     = ctrl_q[6:4];
   assign freq_from_reg = ctrl_q[3];
   assign spread_down   = ctrl_q[2];
   assign spread_en     = ctrl_q[1];
   assign all_hiz       = ctrl_q[0];
   assign cpu_en        = ctrl_q[15:8];
   assign pci_en        = ctrl_q[23:16];
   assign sdram_en_lo   = ctrl_q[31:24];
   assign sdram_en_hi   = ctrl_q[39:32];
   assign periph_en     = ctrl_q[47:40];
endmodule

// File: tb/clkgen_cfg_slave_tb.sv
module clkgen_cfg_slave_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic sda_bus;
   logic spread_narrow, freq_from_reg, spread_down, spread_en, all_hiz;
   logic [2:0] freq_code;
   logic [7:0] cpu_en, pci_en, sdram_en_lo, sdram_en_hi, periph_en;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit cmp_hold = 1'b0;
   bit done = 1'b0;
   logic [7:0] m_reg [7];

   always #2 clk = ~clk;
   assign sda_bus = !(m_low || sda_oe);

   clkgen_cfg_slave u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
      .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .spread_narrow(spread_narrow), .freq_code(freq_code),
      .freq_from_reg(freq_from_reg), .spread_down(spread_down),
      .spread_en(spread_en), .all_hiz(all_hiz),
      .cpu_en(cpu_en), .pci_en(pci_en), .sdram_en_lo(sdram_en_lo),
      .sdram_en_hi(sdram_en_hi), .periph_en(periph_en)
   );

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the reference registers
   always @(negedge clk) begin
      if (cmp_on && !cmp_hold) begin
         check8("R6 R7 reg0 fields",
                {spread_narrow, freq_code, freq_from_reg, spread_down, spread_en, all_hiz},
                m_reg[0]);
         check8("R11 cpu_en", cpu_en, m_reg[1]);
         check8("R11 pci_en", pci_en, m_reg[2]);
         check8("R11 sdram_en_lo", sdram_en_lo, m_reg[3]);
         check8("R11 sdram_en_hi", sdram_en_hi, m_reg[4]);
         check8("R11 periph_en", periph_en, m_reg[5]);
      end
      if (cmp_on && pwr_dn) check8("R8 sda released", {7'd0, sda_oe}, 8'd0);
   end

   task automatic q_wait();
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; q_wait();
      scl = 1'b1;   q_wait();
      m_low = 1'b1; q_wait();
      scl = 1'b0;   q_wait();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; q_wait();
      scl = 1'b1;   q_wait();
      m_low = 1'b0; q_wait();
   endtask

   task automatic put_bit(input logic b);
      m_low = ~b; q_wait();
      scl = 1'b1; q_wait(); q_wait();
      scl = 1'b0; q_wait();
   endtask

   task automatic get_bit(output logic b);
      m_low = 1'b0; q_wait();
      scl = 1'b1;   q_wait();
      b = sda_bus;  q_wait();
      scl = 1'b0;   q_wait();
   endtask

   // send one byte; midx >= 0 marks a register the model updates after the ack
   task automatic send(input logic [7:0] d, input bit exp_ack, input string req, input int midx);
      logic a;
      for (int i = 7; i >= 1; i--) put_bit(d[i]);
      cmp_hold = 1'b1;
      put_bit(d[0]);
      get_bit(a);
      check8(req, {7'd0, ~a}, {7'd0, exp_ack});
      if (midx >= 0 && midx < 7) m_reg[midx] = d;
      cmp_hold = 1'b0;
   endtask

   task automatic recv(output logic [7:0] d, input logic nack);
      for (int i = 7; i >= 0; i--) get_bit(d[i]);
      put_bit(nack);
   endtask

   task automatic read_all(input string req);
      logic [7:0] d;
      bus_start();
      send(8'hD3, 1'b1, "R1 read address ack", -1);
      for (int i = 0; i < 8; i++) begin
         recv(d, (i == 7));
         check8(req, d, (i < 7) ? m_reg[i] : 8'hFF);
      end
      bus_stop();
   endtask

   initial begin
      m_reg[0] = 8'h00;
      for (int i = 1; i < 7; i++) m_reg[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R5 reset values
      check8("R5 reg0 reset", {spread_narrow, freq_code, freq_from_reg, spread_down, spread_en, all_hiz}, 8'h00);
      check8("R5 reg1 reset", cpu_en, 8'hFF);
      check8("R5 reg5 reset", periph_en, 8'hFF);
      check8("R8 idle sda", {7'd0, sda_oe}, 8'd0);
      cmp_on = 1'b1;
      read_all("R5 R4 readback after reset");

      // R1 R2 R3: block write of three data bytes
      bus_start();
      send(8'hD2, 1'b1, "R1 write address ack", -1);
      send(8'h55, 1'b1, "R2 command byte ack", -1);
      send(8'h09, 1'b1, "R2 count byte ack", -1);
      send(8'hB6, 1'b1, "R3 data0 ack", 0);
      send(8'h0F, 1'b1, "R3 data1 ack", 1);
      send(8'hA5, 1'b1, "R3 data2 ack", 2);
      bus_stop();
      repeat (4) @(negedge clk);
      check8("R6 spread_narrow", {7'd0, spread_narrow}, 8'd1);
      check8("R6 freq_code", {5'd0, freq_code}, 8'd3);
      check8("R6 freq_from_reg", {7'd0, freq_from_reg}, 8'd0);
      check8("R7 spread_down", {7'd0, spread_down}, 8'd1);
      check8("R7 spread_en", {7'd0, spread_en}, 8'd1);
      check8("R7 all_hiz", {7'd0, all_hiz}, 8'd0);
      read_all("R4 streamed readback");

      // R1 foreign address ignored
      bus_start();
      send(8'hA4, 1'b0, "R1 foreign address nack", -1);
      send(8'h00, 1'b0, "R1 foreign data nack", -1);
      bus_stop();

      // R10 write past the last register
      bus_start();
      send(8'hD2, 1'b1, "R1 write address ack", -1);
      send(8'h00, 1'b1, "R2 command ack", -1);
      send(8'h00, 1'b1, "R2 count ack", -1);
      for (int i = 0; i < 9; i++)
         send(8'h48 + 8'(i * 17), 1'b1, "R10 overflow ack", (i < 7) ? i : -1);
      bus_stop();
      read_all("R10 R11 readback incl reg6 and 0xFF tail");

      // R9 STOP inside a byte
      bus_start();
      send(8'hD2, 1'b1, "R1 write address ack", -1);
      send(8'h11, 1'b1, "R2 command ack", -1);
      send(8'h22, 1'b1, "R2 count ack", -1);
      send(8'h3C, 1'b1, "R3 data0 ack", 0);
      for (int i = 0; i < 5; i++) put_bit(1'b0);
      bus_stop();
      repeat (4) @(negedge clk);
      check8("R9 reg1 kept after cut byte", cpu_en, m_reg[1]);

      // R9 repeated START inside a byte, then read back
      bus_start();
      send(8'hD2, 1'b1, "R1 write address ack", -1);
      send(8'h00, 1'b1, "R2 command ack", -1);
      send(8'h00, 1'b1, "R2 count ack", -1);
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      read_all("R9 readback after repeated start");

      // R8 power-down
      pwr_dn = 1'b1;
      repeat (4) @(negedge clk);
      bus_start();
      send(8'hD2, 1'b0, "R8 address ignored in power-down", -1);
      send(8'h00, 1'b0, "R8 data ignored in power-down", -1);
      send(8'h00, 1'b0, "R8 data ignored in power-down", -1);
      send(8'h01, 1'b0, "R8 data ignored in power-down", -1);
      bus_stop();
      check8("R8 reg0 retained", {spread_narrow, freq_code, freq_from_reg, spread_down, spread_en, all_hiz}, m_reg[0]);
      pwr_dn = 1'b0;
      repeat (4) @(negedge clk);
      bus_start();
      send(8'hD2, 1'b1, "R8 write after wake", -1);
      send(8'h00, 1'b1, "R2 command ack", -1);
      send(8'h00, 1'b1, "R2 count ack", -1);
      send(8'h49, 1'b1, "R7 data0 ack", 0);
      bus_stop();
      repeat (4) @(negedge clk);
      check8("R7 all_hiz set", {7'd0, all_hiz}, 8'd1);
      check8("R6 freq_from_reg set", {7'd0, freq_from_reg}, 8'd1);
      check8("R6 freq_code 4", {5'd0, freq_code}, 8'd4);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule